// File: doc/BRIEF.md
# Programmable Threshold Status Flags for a Word Queue

This block produces the two occupancy status outputs of a first-in, first-out word queue: a half-level flag and a single boundary flag that is raised whenever the queue is close to either end of its range. It follows the queue's occupancy itself. A write strobe adds one word and a read strobe removes one. The range runs from zero up to the queue depth plus one, the extra word being the one held in the output register.

The boundary flag is set by an offset X. A falling edge on the active-low define input stores X from the low data bits into a holding register, and this can happen at any time. The offset that the comparators actually use sits in a separate register, and it changes only when reset is released. At that point the define level decides its source. A low level selects the stored value, and a high level selects the built-in default. If define is left low, no new falling edge occurs, so the same stored value is reused at every reset.

A two-state phase machine governs the block. HOLD is entered on any clock where reset is low. The transition HOLD to RUN, on the first clock with reset high, commits the offset. The transition RUN to HOLD occurs when reset is asserted again.

Top module: `thresh_flags`

## Requirements
- R1: While reset is low the half flag is 0 and the boundary flag is 1, and the occupancy is cleared to zero, so the flags read 0 and 1 on the first clock after release.
- R2: On a clock with reset high, a write strobe alone raises the occupancy by one and a read strobe alone lowers it by one. Both strobes together, or neither, leave it unchanged. It saturates at 0 and at DEPTH+1.
- R3: The boundary flag is 1 when occupancy is at most X+1 or at least DEPTH+1-X, and 0 otherwise. Here X is the active offset.
- R4: The half flag is 1 when occupancy is at least DEPTH/2, and 0 otherwise.
- R5: Both flags are registered and reflect the occupancy produced by the same clock edge that applied the strobes.
- R6: A define input sampled high on one clock and low on the next stores the low OFS_W data bits as the offset. The strobes have no effect on this capture.
- R7: On the clock that leaves reset with define low, the active offset becomes the stored offset. Capture and commit may fall on the same clock, and the newly captured value is then used.
- R8: On the clock that leaves reset with define high, the active offset becomes DEF_OFS.
- R9: A capture made while running does not change the flags' thresholds until the next reset release.
- R10: Keeping define low across a later reset, with no new falling edge, recommits the previously stored offset even if the data bits have changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset, active low, sampled on the clock |
| def_n | input | 1 | Define input, active low; its falling edge captures the offset |
| ofs_in | input | OFS_W | Low data bits captured as the offset |
| wr_evt | input | 1 | One word written this clock |
| rd_evt | input | 1 | One word read this clock |
| half_full | output | 1 | Occupancy at or above half the depth |
| near_edge | output | 1 | Occupancy within the offset band of empty or full |

## Verification
A small configuration (depth 16, three-bit offset, default 4) is swept over every offset value. For each offset, the occupancy is ramped up past saturation and back down past zero, so that every count is compared against both thresholds and both saturation points are hit. Mixed strobe clocks separate a correct hold from a miscounted step. A reset sequence then contrasts the three offset sources: a fresh capture, the retained value with define kept low, and the default with define high. A capture made while running is then checked to leave the thresholds unchanged until the following release.

// File: rtl/thresh_pkg.sv
package thresh_pkg;

    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } phase_e;

    function automatic logic in_edge_band(input int cnt, input int ofs, input int cap);
        return (cnt <= ofs + 1) || (cnt >= cap - ofs);
    endfunction

endpackage

// File: rtl/occ_counter.sv
module occ_counter #(
    parameter int DEPTH = 1024,
    localparam int CAP   = DEPTH + 1,
    localparam int CNT_W = $clog2(CAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_evt,
    input  logic             rd_evt,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);

    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAP);

    always_comb begin
        cnt_nxt = cnt_q;
        if (clear) begin
            cnt_nxt = '0;
        end else if (wr_evt && !rd_evt && cnt_q != CAP_V) begin
            cnt_nxt = cnt_q + 1'b1;
        end else if (rd_evt && !wr_evt && cnt_q != '0) begin
            cnt_nxt = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_nxt;
    end

    // R2: single write step raises by one below the ceiling
    p_cnt_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && !rd_evt && cnt_q < CAP_V) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R2: occupancy never leaves its range
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= CAP_V) |=> (cnt_q <= CAP_V));

endmodule

// File: rtl/ofs_store.sv
module ofs_store #(
    parameter int OFS_W   = 9,
    parameter int DEF_OFS = 256
) (
    input  logic             clk,
    input  logic             def_n,
    input  logic [OFS_W-1:0] ofs_in,
    input  logic             commit,
    output logic [OFS_W-1:0] ofs_active_q,
    output logic [OFS_W-1:0] ofs_active_nxt
);

    localparam logic [OFS_W-1:0] DEF_V = OFS_W'(DEF_OFS);

    logic             def_d_q;
    logic [OFS_W-1:0] ofs_held_q;
    logic [OFS_W-1:0] ofs_held_nxt;
    logic             capture;

    assign capture      = def_d_q && !def_n;
    assign ofs_held_nxt = capture ? ofs_in : ofs_held_q;

    always_comb begin
        ofs_active_nxt = ofs_active_q;
        if (commit) begin
            ofs_active_nxt = def_n ? DEF_V : ofs_held_nxt;
        end
    end

    always_ff @(posedge clk) begin
        def_d_q      <= def_n;
        ofs_held_q   <= ofs_held_nxt;
        ofs_active_q <= ofs_active_nxt;
    end

endmodule

// File: rtl/flag_gen.sv
module flag_gen #(
    parameter int DEPTH = 1024,
    parameter int OFS_W = 9,
    localparam int CAP   = DEPTH + 1,
    localparam int HALF  = DEPTH / 2,
    localparam int CNT_W = $clog2(CAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [OFS_W-1:0] ofs_nxt,
    output logic             half_q,
    output logic             edge_q
);

    import thresh_pkg::*;

    logic half_d;
    logic edge_d;

    always_comb begin
        if (clear) begin
            half_d = 1'b0;
            edge_d = 1'b1;
        end else begin
            half_d = (int'(cnt_nxt) >= HALF);
            edge_d = in_edge_band(int'(cnt_nxt), int'(ofs_nxt), CAP);
        end
    end

    always_ff @(posedge clk) begin
        half_q <= half_d;
        edge_q <= edge_d;
    end

    // R4: half flag agrees with the registered occupancy
    p_half_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
        half_q == (int'(cnt_q) >= HALF));

    // R3: both ends empty/full are always inside the band
    p_edge_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 || int'(cnt_q) == CAP) |-> edge_q);

endmodule

// File: rtl/thresh_flags.sv
module thresh_flags #(
    parameter int DEPTH   = 1024,
    parameter int OFS_W   = 9,
    parameter int DEF_OFS = 256,
    localparam int CAP   = DEPTH + 1,
    localparam int CNT_W = $clog2(CAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             def_n,
    input  logic [OFS_W-1:0] ofs_in,
    input  logic             wr_evt,
    input  logic             rd_evt,
    output logic             half_full,
    output logic             near_edge
);

    import thresh_pkg::*;

    phase_e           st_q;
    phase_e           st_nxt;
    logic             commit;
    logic             clear;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [OFS_W-1:0] ofs_act_q;
    logic [OFS_W-1:0] ofs_act_nxt;

    // phase transitions
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_HOLD: if (rst_n)  st_nxt = ST_RUN;
            ST_RUN:  if (!rst_n) st_nxt = ST_HOLD;
            default: st_nxt = ST_HOLD;
        endcase
        if (!rst_n) st_nxt = ST_HOLD;
    end

    always_ff @(posedge clk) begin
        st_q <= st_nxt;
    end

    // phase outputs
    always_comb begin
        commit = 1'b0;
        clear  = 1'b0;
        unique case (st_q)
            ST_HOLD: begin
                clear  = !rst_n;
                commit = rst_n;
            end
            ST_RUN: begin
                clear  = !rst_n;
            end
            default: clear = 1'b1;
        endcase
    end

    occ_counter #(.DEPTH(DEPTH)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .wr_evt  (wr_evt),
        .rd_evt  (rd_evt),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    ofs_store #(.OFS_W(OFS_W), .DEF_OFS(DEF_OFS)) u_ofs (
        .clk            (clk),
        .def_n          (def_n),
        .ofs_in         (ofs_in),
        .commit         (commit),
        .ofs_active_q   (ofs_act_q),
        .ofs_active_nxt (ofs_act_nxt)
    );

    flag_gen #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .cnt_nxt (cnt_nxt),
        .cnt_q   (cnt_q),
        .ofs_nxt (ofs_act_nxt),
        .half_q  (half_full),
        .edge_q  (near_edge)
    );

    // R1: first clock after release still shows the reset flag values
    p_release_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (near_edge && !half_full));

    // R9: the active offset is frozen while running
    p_ofs_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |=> $stable(ofs_act_q));

    // R8: release with define high loads the default
    p_commit_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && def_n) |=> (ofs_act_q == OFS_W'(DEF_OFS)));

endmodule

// File: tb/thresh_flags_tb.sv
module thresh_flags_tb;

    localparam int DEPTH   = 16;
    localparam int OFS_W   = 3;
    localparam int DEF_OFS = 4;
    localparam int CAP     = DEPTH + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             def_n = 1'b1;
    logic [OFS_W-1:0] ofs_in = '0;
    logic             wr_evt = 1'b0;
    logic             rd_evt = 1'b0;
    logic             half_full;
    logic             near_edge;

    int checks = 0;
    int failures = 0;
    int m_cnt = 0;
    int m_ofs = DEF_OFS;
    logic done = 1'b0;

    always #4 clk = ~clk;

    thresh_flags #(.DEPTH(DEPTH), .OFS_W(OFS_W), .DEF_OFS(DEF_OFS)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .def_n     (def_n),
        .ofs_in    (ofs_in),
        .wr_evt    (wr_evt),
        .rd_evt    (rd_evt),
        .half_full (half_full),
        .near_edge (near_edge)
    );

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cnt=%0d ofs=%0d actual=%0b expected=%0b", req, m_cnt, m_ofs, act, exp);
        end
    endtask

    task automatic check_flags(input string req);
        logic e_edge;
        logic e_half;
        e_edge = ((m_cnt - m_ofs) <= 1) || ((m_cnt + m_ofs) >= CAP);
        e_half = (2 * m_cnt >= DEPTH);
        check_bit({req, " R3 edge"}, near_edge, e_edge);
        check_bit({req, " R4 half"}, half_full, e_half);
    endtask

    // R2 R5: apply strobes for one clock, update model, check after the edge
    task automatic step(input logic w, input logic r);
        @(negedge clk);
        wr_evt = w;
        rd_evt = r;
        @(posedge clk);
        if (w && !r && m_cnt < CAP) m_cnt++;
        else if (r && !w && m_cnt > 0) m_cnt--;
        #1;
        check_flags("R2 R5");
        @(negedge clk);
        wr_evt = 1'b0;
        rd_evt = 1'b0;
    endtask

    // reset cycle; fall_now creates a define falling edge with data x;
    // def_lvl is the define level at release
    task automatic reset_cycle(input logic fall_now, input int x, input logic def_lvl);
        @(negedge clk);
        rst_n  = 1'b0;
        wr_evt = 1'b1;
        if (fall_now) def_n = 1'b1;
        @(posedge clk);
        #1;
        check_bit("R1 edge in reset", near_edge, 1'b1);
        check_bit("R1 half in reset", half_full, 1'b0);
        @(negedge clk);
        ofs_in = OFS_W'(x);
        if (fall_now) def_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        def_n  = def_lvl;
        wr_evt = 1'b0;
        rst_n  = 1'b1;
        @(posedge clk);
        m_cnt = 0;
        #1;
        check_bit("R1 edge after release", near_edge, 1'b1);
        check_bit("R1 half after release", half_full, 1'b0);
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < CAP + 2; i++) step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        for (int i = 0; i < CAP + 2; i++) begin
            step(1'b0, 1'b1);
            if (i == 3) step(1'b1, 1'b1);
        end
        for (int i = 0; i < m_ofs + 3; i++) step(1'b1, 1'b0);
        check_flags(req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // R6 R7: program every offset and sweep the whole range
        for (int x = 0; x < (1 << OFS_W); x++) begin
            reset_cycle(1'b1, x, 1'b0);
            m_ofs = x;
            sweep("R6 R7");
        end
        // R10: define kept low, data changed, no new edge
        reset_cycle(1'b1, 2, 1'b0);
        m_ofs = 2;
        reset_cycle(1'b0, 6, 1'b0);
        sweep("R10 retained");
        // R8: define high at release selects the default
        reset_cycle(1'b0, 6, 1'b1);
        m_ofs = DEF_OFS;
        sweep("R8 default");
        // R9: capture while running with strobes active, thresholds unchanged
        @(negedge clk);
        ofs_in = OFS_W'(1);
        def_n  = 1'b0;
        wr_evt = 1'b1;
        rd_evt = 1'b1;
        @(negedge clk);
        wr_evt = 1'b0;
        rd_evt = 1'b0;
        sweep("R9 frozen");
        // R6: the running capture commits at the next release
        reset_cycle(1'b0, 5, 1'b0);
        m_ofs = 1;
        sweep("R6 later commit");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule